// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Sequencer

This block sits between a processor's memory port and a DRAM whose row and column addresses share one set of address pins. The processor presents a full word address, a write word, a read/write line and a one-cycle request. The block splits the address into a row field and a column field and places each on the shared bus. It drives the active-low row strobe, column strobe, write enable and output enable, each held for a set number of clock cycles. When the access is done it returns a one-cycle completion pulse, and for a read it also returns the captured word.

All timing is counted in clock cycles and set by parameters: address setup before each strobe, address hold after each strobe, read access time and row precharge. The processor chooses, per request, whether a read enables the DRAM outputs early or late. Early means after the row strobe and before the column address. Late means only once the column strobe has been low for the hold time. After an access the row stays open. A later request to the same row runs only a new column cycle. A request to a different row first closes the open row for the precharge time.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset all four DRAM strobes are high (inactive), the data bus is not driven and the completion pulse is low.
- R2: An access that opens a row places the row field on the address bus with the row strobe high for T_SU cycles. The row strobe then falls and the row field stays on the bus for T_HOLD more cycles.
- R3: Every access places the column field on the bus for T_SU cycles with the column strobe high. The column strobe then falls with the column field held on the bus. The column strobe is low only while the row strobe is low.
- R4: An early read drops output enable for one cycle with the row field still on the bus, after the row phase (or at once on a page hit). Output enable stays low through the column phase and the access wait.
- R5: A late read keeps output enable high until the column strobe has been low for T_HOLD cycles. Output enable then falls and stays low for T_ACC cycles.
- R6: A read returns on the read-data port the DRAM data word present in the last access cycle. The word is valid in the cycle where the completion pulse is high.
- R7: A write drops write enable and drives the write word on the data bus from the first column-setup cycle until the end of the column hold. Output enable stays high for the whole write.
- R8: The read/write line is 1 for a read and 0 for a write. The completion pulse is high for exactly one cycle. It comes 2·T_SU+2·T_HOLD+1 cycles after the request is sampled on a cold start, plus T_ACC for reads, plus 1 for an early read.
- R9: A request whose row field equals the open row keeps the row strobe low throughout and runs only the column phase.
- R10: A request to a different row raises the row strobe for T_PRE cycles before the row setup of the new row begins.
- R11: A request raised while an access is in progress is ignored. It neither changes the timing of that access nor touches the DRAM.
- R12: The row field is the upper ROW_W bits of the processor address and the column field the lower ADDR_W−ROW_W bits. Each field is zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, sampled when idle |
| cpu_rd_nwr | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | ADDR_W | Word address (row field above column field) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_oe_early | input | 1 | 1 = early output enable for this read, 0 = late |
| cpu_mfc | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Captured read word |
| dram_a | output | MUX_W | Multiplexed row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | High while dram_dq_out is driven |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
A wrong sequencer state shows up at the strobe pins in the same cycle, as an edge that arrives early, arrives late or is missing. The bench records the index of every strobe edge within each access and compares it against arithmetic expectations, so a single extra or skipped state fails the next access. A stale open-row record appears differently. The row strobe rises where none was due, or fails to rise, and the bench's DRAM model then returns data from the wrong row. That shows up as a wrong read word on the first read that follows.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_ROW_SU,
        S_ROW_HOLD,
        S_OE_EARLY,
        S_COL_SU,
        S_COL_HOLD,
        S_ACCESS,
        S_FINISH
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
        logic dq_drive;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                         oe_n: 1'b1, dq_drive: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dseq_delay_ctr.sv
module dseq_delay_ctr #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dseq_row_track.sv
module dseq_row_track #(
    parameter int unsigned ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             is_open,
    output logic             hit
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_clr) begin
            open_q <= 1'b0;
        end else if (open_set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end
    end

    assign is_open = open_q;
    assign hit     = open_q && (row_q == cmp_row);
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int unsigned ROW_W  = 5,
    parameter int unsigned COL_W  = 5,
    parameter int unsigned MUX_W  = 5,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CW     = 2,
    parameter int unsigned T_SU   = 1,
    parameter int unsigned T_HOLD = 1,
    parameter int unsigned T_ACC  = 2,
    parameter int unsigned T_PRE  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              rd_nwr,
    input  logic              oe_early,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cnt_done,
    output logic              cnt_load,
    output logic [CW-1:0]     cnt_val,
    input  logic              row_open,
    input  logic              row_hit,
    output logic              row_set,
    output logic              row_clr,
    output logic [ROW_W-1:0]  lat_row,
    output strobe_t           strobe,
    output logic [MUX_W-1:0]  bus_a,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              mfc
);
    seq_state_e        state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rd_q, early_q;

    function automatic logic [CW-1:0] dur(input seq_state_e s);
        case (s)
            S_PRE:                 return CW'(T_PRE - 1);
            S_ROW_SU, S_COL_SU:    return CW'(T_SU - 1);
            S_ROW_HOLD, S_COL_HOLD: return CW'(T_HOLD - 1);
            S_ACCESS:              return CW'(T_ACC - 1);
            default:               return '0;
        endcase
    endfunction

    // next-state and side effects
    always_comb begin
        state_d = state_q;
        row_set = 1'b0;
        row_clr = 1'b0;
        unique case (state_q)
            S_IDLE: if (req) begin
                if (row_hit)
                    state_d = (rd_nwr && oe_early) ? S_OE_EARLY : S_COL_SU;
                else if (row_open) begin
                    state_d = S_PRE;
                    row_clr = 1'b1;
                end else
                    state_d = S_ROW_SU;
            end
            S_PRE:      if (cnt_done) state_d = S_ROW_SU;
            S_ROW_SU:   if (cnt_done) begin
                state_d = S_ROW_HOLD;
                row_set = 1'b1;
            end
            S_ROW_HOLD: if (cnt_done) state_d = (rd_q && early_q) ? S_OE_EARLY : S_COL_SU;
            S_OE_EARLY: state_d = S_COL_SU;
            S_COL_SU:   if (cnt_done) state_d = S_COL_HOLD;
            S_COL_HOLD: if (cnt_done) state_d = rd_q ? S_ACCESS : S_FINISH;
            S_ACCESS:   if (cnt_done) state_d = S_FINISH;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
        cnt_load = (state_d != state_q);
        cnt_val  = dur(state_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            rd_q    <= 1'b0;
            early_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req) begin
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= wdata;
                rd_q    <= rd_nwr;
                early_q <= oe_early;
            end
            if (state_q == S_ACCESS && cnt_done)
                rdata_q <= dq_in;
        end
    end

    // strobe and bus decode from the registered state
    always_comb begin
        strobe = STROBE_QUIET;
        bus_a  = '0;
        mfc    = 1'b0;
        unique case (state_q)
            S_IDLE: strobe.ras_n = !row_open;
            S_PRE, S_ROW_SU: bus_a = MUX_W'(row_q);
            S_ROW_HOLD: begin
                strobe.ras_n = 1'b0;
                bus_a        = MUX_W'(row_q);
            end
            S_OE_EARLY: begin
                strobe.ras_n = 1'b0;
                strobe.oe_n  = 1'b0;
                bus_a        = MUX_W'(row_q);
            end
            S_COL_SU, S_COL_HOLD: begin
                strobe.ras_n    = 1'b0;
                strobe.cas_n    = (state_q == S_COL_SU);
                strobe.we_n     = rd_q;
                strobe.dq_drive = !rd_q;
                strobe.oe_n     = !(rd_q && early_q);
                bus_a           = MUX_W'(col_q);
            end
            S_ACCESS: begin
                strobe.ras_n = 1'b0;
                strobe.cas_n = 1'b0;
                strobe.oe_n  = 1'b0;
                bus_a        = MUX_W'(col_q);
            end
            S_FINISH: begin
                strobe.ras_n = 1'b0;
                bus_a        = MUX_W'(col_q);
                mfc          = 1'b1;
            end
            default: strobe = STROBE_QUIET;
        endcase
    end

    assign lat_row = row_q;
    assign dq_out  = wdata_q;
    assign rdata   = rdata_q;
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned ROW_W  = 5,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned T_SU   = 1,
    parameter int unsigned T_HOLD = 1,
    parameter int unsigned T_ACC  = 2,
    parameter int unsigned T_PRE  = 2,
    localparam int unsigned COL_W = ADDR_W - ROW_W,
    localparam int unsigned MUX_W = max2(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_rd_nwr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_oe_early,
    output logic              cpu_mfc,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [MUX_W-1:0]  dram_a,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int unsigned T_MAX = max2(max2(T_SU, T_HOLD), max2(T_ACC, T_PRE));
    localparam int unsigned CW    = $clog2(T_MAX + 1);

    logic             cnt_load, cnt_done;
    logic [CW-1:0]    cnt_val;
    logic             row_open, row_hit, row_set, row_clr;
    logic [ROW_W-1:0] lat_row;
    strobe_t          strobe;

    dseq_delay_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
    );

    dseq_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst(rst), .open_set(row_set), .open_clr(row_clr),
        .set_row(lat_row), .cmp_row(cpu_addr[ADDR_W-1:COL_W]),
        .is_open(row_open), .hit(row_hit)
    );

    dseq_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W), .DATA_W(DATA_W), .CW(CW),
        .T_SU(T_SU), .T_HOLD(T_HOLD), .T_ACC(T_ACC), .T_PRE(T_PRE)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req(cpu_req), .rd_nwr(cpu_rd_nwr), .oe_early(cpu_oe_early),
        .req_row(cpu_addr[ADDR_W-1:COL_W]), .req_col(cpu_addr[COL_W-1:0]), .wdata(cpu_wdata),
        .cnt_done(cnt_done), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .row_open(row_open), .row_hit(row_hit), .row_set(row_set), .row_clr(row_clr),
        .lat_row(lat_row), .strobe(strobe), .bus_a(dram_a), .dq_out(dram_dq_out),
        .dq_in(dram_dq_in), .rdata(cpu_rdata), .mfc(cpu_mfc)
    );

    assign dram_ras_n = strobe.ras_n;
    assign dram_cas_n = strobe.cas_n;
    assign dram_we_n  = strobe.we_n;
    assign dram_oe_n  = strobe.oe_n;
    assign dram_dq_oe = strobe.dq_drive;
endmodule

// File: rtl/dram_strobe_seq_chk.sv
module dram_strobe_seq_chk #(
    parameter int unsigned MUX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             mfc,
    input logic [MUX_W-1:0] bus_a,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe
);
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);                                         // R3
    AST_COL_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cas_n |=> (cas_n || $stable(bus_a)));                      // R3
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n);                                            // R7
    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !we_n);                                           // R7
    AST_MFC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mfc |=> !mfc);                                              // R8
    AST_MFC_STROBES_IDLE: assert property (@(posedge clk) disable iff (rst)
        mfc |-> (cas_n && oe_n && we_n));                           // R8
endmodule

bind dram_strobe_seq dram_strobe_seq_chk #(.MUX_W(MUX_W)) u_chk (
    .clk(clk), .rst(rst), .mfc(cpu_mfc), .bus_a(dram_a), .ras_n(dram_ras_n),
    .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe)
);

// File: tb/dram_strobe_seq_bench.sv
module dram_strobe_seq_bench;
    localparam int ADDR_W = 6, ROW_W = 3, COL_W = 3, DATA_W = 8;
    localparam int T_SU = 2, T_HOLD = 3, T_ACC = 3, T_PRE = 2;
    localparam int NW = 1 << ADDR_W;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req = 1'b0, cpu_rd_nwr = 1'b1, cpu_oe_early = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_mfc, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DATA_W-1:0] cpu_rdata, dram_dq_out, dram_dq_in;
    logic [COL_W-1:0] dram_a;

    int vectors = 0, miscompares = 0, cycles = 0;
    logic [DATA_W-1:0] shadow [NW];
    logic [DATA_W-1:0] mem [NW];
    logic [ROW_W-1:0] m_row = '0;
    logic [COL_W-1:0] m_col = '0;
    logic m_pras = 1'b1, m_pcas = 1'b1;
    bit open_v = 1'b0;
    int open_row = 0;

    always #4 clk = ~clk;

    dram_strobe_seq #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W),
        .T_SU(T_SU), .T_HOLD(T_HOLD), .T_ACC(T_ACC), .T_PRE(T_PRE)
    ) u_dram_strobe_seq (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_rd_nwr(cpu_rd_nwr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_oe_early(cpu_oe_early),
        .cpu_mfc(cpu_mfc), .cpu_rdata(cpu_rdata), .dram_a(dram_a),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    // behavioural DRAM: latches row and column on strobe falls
    always @(negedge clk) begin
        if (m_pras && !dram_ras_n) m_row <= dram_a;
        if (m_pcas && !dram_cas_n) begin
            m_col <= dram_a;
            if (!dram_we_n) mem[{m_row, dram_a}] <= dram_dq_out;
        end
        m_pras <= dram_ras_n;
        m_pcas <= dram_cas_n;
    end
    assign dram_dq_in = mem[{m_row, m_col}];

    function automatic logic [DATA_W-1:0] pat(input int a);
        return DATA_W'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(input bit rd, input int addr, input bit early, input bit interfere);
        int row = addr >> COL_W;
        int col = addr & ((1 << COL_W) - 1);
        bit hit  = open_v && (open_row == row);
        bit miss = open_v && (open_row != row);
        int pre  = miss ? T_PRE : 0;
        int rowph = hit ? 0 : T_SU + T_HOLD;
        int eo   = (rd && early) ? 1 : 0;
        int c0   = 1 + pre + rowph + eo;
        int cas_e = c0 + T_SU;
        int mfc_e = cas_e + T_HOLD + (rd ? T_ACC : 0);
        int ras_e = hit ? 0 : 1 + pre + T_SU;
        int oe_e  = !rd ? 0 : (early ? 1 + pre + rowph : cas_e + T_HOLD);
        int we_e  = rd ? 0 : c0;
        int ras_f = 0, ras_r = 0, cas_f = 0, oe_f = 0, we_f = 0, idx = 0;
        logic p_ras, p_cas, p_oe, p_we;
        p_ras = dram_ras_n; p_cas = dram_cas_n; p_oe = dram_oe_n; p_we = dram_we_n;
        cpu_req = 1'b1; cpu_rd_nwr = rd; cpu_addr = ADDR_W'(addr);
        cpu_wdata = pat(addr); cpu_oe_early = early;
        @(posedge clk);
        @(negedge clk);
        cpu_req = interfere;
        if (interfere) begin
            cpu_rd_nwr = 1'b0; cpu_addr = ADDR_W'(addr ^ (NW - 1)); cpu_wdata = ~pat(addr);
        end
        for (int i = 1; i <= 80; i++) begin
            if (p_ras && !dram_ras_n && ras_f == 0) begin
                ras_f = i;
                chk(int'(dram_a) == row, "R12 row field at row strobe", int'(dram_a), row);
            end
            if (!p_ras && dram_ras_n && ras_r == 0) ras_r = i;
            if (p_cas && !dram_cas_n && cas_f == 0) begin
                cas_f = i;
                chk(int'(dram_a) == col, "R12 column field at column strobe", int'(dram_a), col);
            end
            if (p_oe && !dram_oe_n && oe_f == 0) oe_f = i;
            if (p_we && !dram_we_n && we_f == 0) begin
                we_f = i;
                chk(dram_dq_oe && dram_dq_out == pat(addr), "R7 write data driven",
                    int'(dram_dq_out), int'(pat(addr)));
            end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_oe = dram_oe_n; p_we = dram_we_n;
            if (cpu_mfc) begin idx = i; break; end
            @(negedge clk);
        end
        cpu_req = 1'b0;
        chk(idx == mfc_e, interfere ? "R11 busy request ignored, latency" : "R8 completion latency",
            idx, mfc_e);
        chk(cas_f == cas_e, "R3 column strobe cycle", cas_f, cas_e);
        if (hit) chk(ras_f == 0 && ras_r == 0, "R9 row strobe held on page hit", ras_f + ras_r, 0);
        else if (miss) begin
            chk(ras_r == 1, "R10 precharge row strobe rise", ras_r, 1);
            chk(ras_f == ras_e, "R10 row strobe after precharge", ras_f, ras_e);
        end else chk(ras_f == ras_e, "R2 row strobe cycle", ras_f, ras_e);
        if (!rd) chk(oe_f == 0, "R7 output enable high in write", oe_f, 0);
        else if (early) chk(oe_f == oe_e, "R4 early output enable cycle", oe_f, oe_e);
        else chk(oe_f == oe_e, "R5 late output enable cycle", oe_f, oe_e);
        chk(we_f == we_e, "R7 write enable cycle", we_f, we_e);
        if (rd) chk(cpu_rdata == shadow[addr], "R6 read word", int'(cpu_rdata), int'(shadow[addr]));
        else shadow[addr] = pat(addr);
        open_v = 1'b1; open_row = row;
        @(negedge clk);
        chk(!cpu_mfc, "R8 completion single cycle", int'(cpu_mfc), 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            cycles++;
        end
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !cpu_mfc,
            "R1 reset levels", int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
        rst = 1'b0;
        @(negedge clk);
        chk(dram_ras_n && !cpu_mfc, "R1 idle after reset", int'(dram_ras_n), 1);
        // writes, row-major: mostly page hits
        for (int a = 0; a < NW; a++) access(1'b0, a, a[0], 1'b0);
        // reads, column-major: every access changes row
        for (int c = 0; c < (1 << COL_W); c++)
            for (int r = 0; r < (1 << ROW_W); r++)
                access(1'b1, (r << COL_W) | c, (r + c) % 2 == 1, 1'b0);
        // reads, row-major: page hits in both enable modes
        for (int a = 0; a < NW; a++) access(1'b1, a, a[1], 1'b0);
        // busy-time requests must be ignored (R11)
        access(1'b1, 5, 1'b0, 1'b1);
        access(1'b0, 20, 1'b0, 1'b1);
        access(1'b1, 5 ^ (NW - 1), 1'b1, 1'b0);
        access(1'b1, 20 ^ (NW - 1), 1'b0, 1'b0);
        access(1'b1, 20, 1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule